// File: doc/BRIEF.md
# Register Write-Protection Unlock Controller

This block keeps a small set of configuration registers safe from stray writes. The protected registers are closed after reset. While they are closed, any write to them is dropped. To open them, software writes three key values, one after another, to a single lock register. The key values are 0x59, then 0x16, then 0x88. After the third value, the guarded registers accept writes. The protection stays open until software writes zero to the lock register.

Software can read the lock register to see whether the key took effect, and can send the whole key again until the readback shows the open state. A scratch register that is not protected sits next to the guarded set. Writes to it always take effect, so the gating can be told apart from the bus path itself.

The register bus is a plain synchronous one. It has a word address, a write strobe, write data, a read strobe and registered read data.

Top module: `wprot_ctrl`

## Requirements
- R1: Three writes to address 0 with data exactly 0x00000059, 0x00000016 and 0x00000088, in that order, open the protection. The open state is visible from the cycle after the third write.
- R2: A read of address 0 returns 0x00000001 while open and 0x00000000 while closed. Bits 31:1 always read as zero.
- R3: A write of 0x00000000 to address 0 closes the protection and returns the key tracker to its start, whatever the state was before.
- R4: The protected registers at addresses 1, 2 and 3 keep their value when written while closed. They take the write data when written while open.
- R5: While open, nonzero writes to address 0, including the key values, leave the protection open.
- R6: While closed, a write to address 0 that is not the next expected key value resets the tracker. If that value is 0x00000059, it counts as the first step of a new key.
- R7: After reset the protection is closed and the tracker is at its start. Protected register i (i = 0, 1, 2 at addresses 1, 2, 3) holds CTRL_RST_BASE + i, and the scratch register holds zero.
- R8: The scratch register at address 4 takes every write, whether the protection is open or closed.
- R9: Writes and reads to addresses other than 0, placed between key writes, do not disturb the key tracker.
- R10: Read data is registered. It shows the addressed value in the cycle after the read strobe. It is zero when no read was requested and for unmapped addresses (5 and above).
- R11: A key value with any nonzero bit above bit 7, such as 0x00000159, does not match a key step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The assertions assume that the bus inputs are stable around each rising edge. They also assume that a write and a read in the same cycle are both allowed, and that the read returns the state from before the write. The bench changes its inputs only on falling edges and applies reset synchronously. It mixes key attempts with writes to the guarded, scratch and unmapped addresses, including writes placed between key steps. Because of this, every write is judged against the lock state as it stood in the cycle of the write.

// File: rtl/wprot_pkg.sv
// Package: shared constants and types for the write-protection controller.
// Assumes word addressing with the lock register at address 0.
package wprot_pkg;
    localparam int unsigned LOCK_ADDR = 0;
    localparam int unsigned CTRL_BASE = 1;
    localparam logic [7:0]  KEY_A     = 8'h59;
    localparam logic [7:0]  KEY_B     = 8'h16;
    localparam logic [7:0]  KEY_C     = 8'h88;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GOT1 = 2'd1,
        ST_GOT2 = 2'd2,
        ST_OPEN = 2'd3
    } key_state_t;
endpackage

// File: rtl/key_tracker.sv
// Module: key_tracker
// Follows writes to the lock register and raises unlocked after the three
// key values arrive in order. A zero write closes the protection.
// Assumes write data is compared as a full word (upper bits must be zero).
module key_tracker
    import wprot_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_wr,
    input  logic [DATA_W-1:0] lock_wdata,
    output logic              unlocked
);
    logic       is_a, is_b, is_c, is_zero;
    key_state_t state_q, state_d;

    // Decode the written word against each key value and zero.
    always_comb begin
        is_a    = (lock_wdata == DATA_W'(KEY_A));
        is_b    = (lock_wdata == DATA_W'(KEY_B));
        is_c    = (lock_wdata == DATA_W'(KEY_C));
        is_zero = (lock_wdata == '0);
    end

    // Next-state logic of the key sequence.
    always_comb begin
        state_d = state_q;
        if (lock_wr) begin
            if (is_zero) begin
                state_d = ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_OPEN: state_d = ST_OPEN;
                    ST_GOT1: state_d = is_b ? ST_GOT2 : (is_a ? ST_GOT1 : ST_IDLE);
                    ST_GOT2: state_d = is_c ? ST_OPEN : (is_a ? ST_GOT1 : ST_IDLE);
                    default: state_d = is_a ? ST_GOT1 : ST_IDLE;
                endcase
            end
        end
    end

    // State register, closed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == ST_OPEN);
endmodule

// File: rtl/guard_bank.sv
// Module: guard_bank
// Holds NUM_CTRL protected control words and one unprotected scratch word.
// Protected words change only while open; scratch always changes.
// Assumes addresses CTRL_BASE..CTRL_BASE+NUM_CTRL-1 protected, next is scratch.
module guard_bank
    import wprot_pkg::*;
#(
    parameter int unsigned          ADDR_W        = 4,
    parameter int unsigned          DATA_W        = 32,
    parameter int unsigned          NUM_CTRL      = 3,
    parameter logic [DATA_W-1:0]    CTRL_RST_BASE = 32'hC0DE_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       open,
    output logic [NUM_CTRL*DATA_W-1:0] ctrl_flat,
    output logic [DATA_W-1:0]          scratch
);
    localparam int unsigned SCR_ADDR = CTRL_BASE + NUM_CTRL;

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
        logic [DATA_W-1:0] word_q;
        logic              hit;
        assign hit = wr && (addr == ADDR_W'(CTRL_BASE + i));

        // Protected word: written only while the protection is open.
        always_ff @(posedge clk) begin
            if (!rst_n)          word_q <= CTRL_RST_BASE + DATA_W'(i);
            else if (hit && open) word_q <= wdata;
        end
        assign ctrl_flat[i*DATA_W +: DATA_W] = word_q;
    end

    // Scratch word: written regardless of the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     scratch <= '0;
        else if (wr && (addr == ADDR_W'(SCR_ADDR)))     scratch <= wdata;
    end
endmodule

// File: rtl/rd_mux.sv
// Module: rd_mux
// Selects the addressed register and registers it onto the read bus.
// Assumes unmapped addresses and idle cycles return zero.
module rd_mux
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_CTRL = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       open,
    input  logic [NUM_CTRL*DATA_W-1:0] ctrl_flat,
    input  logic [DATA_W-1:0]          scratch,
    output logic [DATA_W-1:0]          rdata
);
    localparam int unsigned SCR_ADDR = CTRL_BASE + NUM_CTRL;
    logic [DATA_W-1:0] sel;

    // Address decode of the readable registers.
    always_comb begin
        sel = '0;
        if (addr == ADDR_W'(LOCK_ADDR)) sel = DATA_W'(open);
        if (addr == ADDR_W'(SCR_ADDR))  sel = scratch;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (addr == ADDR_W'(CTRL_BASE + i)) sel = ctrl_flat[i*DATA_W +: DATA_W];
        end
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? sel : '0;
    end
endmodule

// File: rtl/wprot_ctrl.sv
// Module: wprot_ctrl (top)
// Write-protection controller: a key tracker at address 0 gates writes to a
// bank of protected registers; a scratch register is never gated.
// Assumes a single-cycle synchronous register bus.
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int unsigned       ADDR_W        = 4,
    parameter int unsigned       DATA_W        = 32,
    parameter int unsigned       NUM_CTRL      = 3,
    parameter logic [DATA_W-1:0] CTRL_RST_BASE = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    logic                       unlocked;
    logic                       lock_wr;
    logic [NUM_CTRL*DATA_W-1:0] ctrl_flat;
    logic [DATA_W-1:0]          scratch;

    assign lock_wr = bus_wr && (bus_addr == ADDR_W'(LOCK_ADDR));

    key_tracker #(.DATA_W(DATA_W)) i_key (
        .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr),
        .lock_wdata(bus_wdata), .unlocked(unlocked)
    );

    guard_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL),
        .CTRL_RST_BASE(CTRL_RST_BASE)
    ) i_bank (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .open(unlocked), .ctrl_flat(ctrl_flat),
        .scratch(scratch)
    );

    rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd(bus_rd), .addr(bus_addr),
        .open(unlocked), .ctrl_flat(ctrl_flat), .scratch(scratch),
        .rdata(bus_rdata)
    );
endmodule

// File: rtl/wprot_checker.sv
// Module: wprot_checker
// Temporal properties of the write-protection controller, bound to the top.
// Assumes inputs are stable around each rising edge.
module wprot_checker
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_CTRL = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_wr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_rd,
    input logic [DATA_W-1:0]          bus_rdata,
    input logic                       unlocked,
    input logic [NUM_CTRL*DATA_W-1:0] ctrl_flat
);
    logic at_lock;
    assign at_lock = (bus_addr == ADDR_W'(LOCK_ADDR));

    a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && at_lock && bus_wdata == DATA_W'(KEY_C)));

    a_r2_lock_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_lock) |=> (bus_rdata == DATA_W'($past(unlocked))));

    a_r3_zero_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_lock && bus_wdata == '0) |=> !unlocked);

    a_r4_closed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |=> $stable(ctrl_flat));

    a_r5_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !(bus_wr && at_lock && bus_wdata == '0)) |=> unlocked);

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind wprot_ctrl wprot_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CTRL(NUM_CTRL)
) i_wprot_checker (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .unlocked(unlocked), .ctrl_flat(ctrl_flat)
);

// File: tb/test_wprot_ctrl.sv
// Bench: behavioural reference model compared every clock, plus directed
// read checks tagged with requirements.
module test_wprot_ctrl;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 32;
    localparam logic [31:0] RBASE  = 32'hC0DE_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    wprot_ctrl i_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // Reference model state
    int          m_step;
    bit          m_open;
    logic [31:0] m_ctrl [3];
    logic [31:0] m_scr;
    logic [31:0] m_rdata;

    function automatic logic [31:0] m_read(input int a);
        if (a == 0)              return {31'd0, m_open};
        if (a >= 1 && a <= 3)    return m_ctrl[a-1];
        if (a == 4)              return m_scr;
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step <= 0; m_open <= 1'b0; m_scr <= '0; m_rdata <= '0;
            for (int i = 0; i < 3; i++) m_ctrl[i] <= RBASE + i;
        end else begin
            m_rdata <= bus_rd ? m_read(int'(bus_addr)) : 32'd0;
            if (bus_wr) begin
                if (bus_addr == 0) begin
                    if (bus_wdata == 0) begin
                        m_open <= 1'b0; m_step <= 0;
                    end else if (!m_open) begin
                        if (m_step == 0 && bus_wdata == 32'h59)      m_step <= 1;
                        else if (m_step == 1 && bus_wdata == 32'h16) m_step <= 2;
                        else if (m_step == 2 && bus_wdata == 32'h88) begin
                            m_open <= 1'b1; m_step <= 0;
                        end else m_step <= (bus_wdata == 32'h59) ? 1 : 0;
                    end
                end else if (bus_addr >= 1 && bus_addr <= 3) begin
                    if (m_open) m_ctrl[bus_addr-1] <= bus_wdata;
                end else if (bus_addr == 4) begin
                    m_scr <= bus_wdata;
                end
            end
        end
    end

    // Every-clock comparison against the model (R10 timing included).
    always @(negedge clk) begin
        n_cmp++;
        if (bus_rdata !== m_rdata) begin
            n_bad++;
            $display("FAIL R10 model compare: rdata=%h expected=%h", bus_rdata, m_rdata);
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = ADDR_W'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        bus_addr = ADDR_W'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        #1;
        n_cmp++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr %0d: actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    task automatic key();
        wr(0, 32'h59); wr(0, 32'h16); wr(0, 32'h88);
    endtask

    initial begin
        fork
            begin
                #1;
                n_cmp++;
                if (bus_rdata !== 32'd0) begin
                    n_bad++;
                    $display("FAIL R7 reset rdata: actual=%h expected=0", bus_rdata);
                end
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R7 reset values
                rd_chk(0, 32'd0, "R7 lock closed");
                rd_chk(1, RBASE, "R7 ctrl0 reset");
                rd_chk(3, RBASE + 2, "R7 ctrl2 reset");
                rd_chk(4, 32'd0, "R7 scratch reset");
                // R4 closed writes ignored, R8 scratch works
                wr(2, 32'hDEAD_BEEF);
                rd_chk(2, RBASE + 1, "R4 closed write ignored");
                wr(4, 32'h1234_5678);
                rd_chk(4, 32'h1234_5678, "R8 scratch closed");
                // R1 open
                key();
                rd_chk(0, 32'd1, "R1/R2 unlocked readback");
                wr(2, 32'hA5A5_0001);
                rd_chk(2, 32'hA5A5_0001, "R4 open write");
                wr(4, 32'h0BAD_F00D);
                rd_chk(4, 32'h0BAD_F00D, "R8 scratch open");
                // R5 nonzero lock writes keep open
                wr(0, 32'h16); wr(0, 32'h59); wr(0, 32'hFFFF_FFFF);
                rd_chk(0, 32'd1, "R5 stays open");
                // R3 close
                wr(0, 32'h0);
                rd_chk(0, 32'd0, "R3 closed");
                wr(1, 32'h1111_1111);
                rd_chk(1, RBASE, "R3/R4 write after close");
                // R6 wrong middle key
                wr(0, 32'h59); wr(0, 32'h16); wr(0, 32'h77); wr(0, 32'h88);
                rd_chk(0, 32'd0, "R6 mismatch stays closed");
                // R6 repeated first key restarts at step one
                wr(0, 32'h59); wr(0, 32'h59); wr(0, 32'h16); wr(0, 32'h88);
                rd_chk(0, 32'd1, "R6 repeated first key");
                wr(0, 32'h0);
                // R3 zero mid-sequence resets tracker
                wr(0, 32'h59); wr(0, 32'h16); wr(0, 32'h0); wr(0, 32'h88);
                rd_chk(0, 32'd0, "R3 zero resets tracker");
                // R11 upper bits
                wr(0, 32'h159); wr(0, 32'h16); wr(0, 32'h88);
                rd_chk(0, 32'd0, "R11 upper bits no match");
                // R9 interleaved accesses
                wr(0, 32'h59);
                wr(4, 32'h0000_00AA);
                wr(0, 32'h16);
                wr(3, 32'h2222_2222);
                rd_chk(3, RBASE + 2, "R9 interleaved protected write ignored");
                wr(0, 32'h88);
                rd_chk(0, 32'd1, "R9 key survives interleaving");
                wr(3, 32'h3333_3333);
                rd_chk(3, 32'h3333_3333, "R4 write after interleaved unlock");
                // R10 unmapped
                wr(7, 32'hFFFF_FFFF);
                rd_chk(7, 32'd0, "R10 unmapped reads zero");
                rd_chk(15, 32'd0, "R10 top address reads zero");
                wr(0, 32'h0);
                rd_chk(0, 32'd0, "R3 final close");
                repeat (2) @(negedge clk);
            end
            begin
                repeat (20000) @(negedge clk);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule